// File: doc/BRIEF.md
# Snooping Five-State Cache Coherence Controller

This block tracks the coherence status of every line of a small direct-mapped, virtually indexed cache on a shared multiprocessor bus. Each line is held in one of five states that combine ownership with dirtiness. The tag and state store is kept in two identical copies. The local request engine reads one copy while the snoop engine reads the other, so a snooped transaction is answered even while a local request is waiting for the bus. Every update is written to both copies at the same time.

Local reads and writes enter through a one-shot request port. The request engine looks up the processor copy of the tags. When the access cannot finish locally, it raises one bus transaction at a time: write-back of a dirty victim, read, read-for-ownership, or invalidate. Each transaction is completed by a one-cycle grant from the external arbiter. Transactions placed on the bus by other masters arrive on the snoop port. For each one the snoop engine returns a shared response, a data-intervention strobe and a memory-reflect strobe in the following cycle, and it updates the line state.

Request engine states: IDLE (ready for a request), LOOKUP (tag compare), WRBACK (victim write-back on the bus), FETCH (line read or read-for-ownership), UPGRADE (invalidate for a write to a shared line), DONE (completion pulse). Transitions: IDLE→LOOKUP on a request; LOOKUP→DONE on a read hit or on a write hit to an exclusive line; LOOKUP→UPGRADE on a write hit to a shared line; LOOKUP→WRBACK on a miss whose victim is dirty; LOOKUP→FETCH on a miss whose victim is clean or invalid; WRBACK→FETCH, FETCH→DONE and UPGRADE→DONE on grant; each bus state returns to LOOKUP if a snoop to the same index arrives before its grant; LOOKUP waits one cycle if a snoop to the same index arrives in the same cycle; DONE→IDLE.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: Line states are INVALID, CLEAN-EXCLUSIVE, CLEAN-SHARED, DIRTY-EXCLUSIVE and DIRTY-OWNED. After reset every line is INVALID, `cpu_ready` is 1, and `bus_req`, `snp_shared_out`, `snp_intervene` and `snp_reflect` are 0.
- R2: A read miss issues bus command READ (code 0) at the request address. The filled line becomes CLEAN-SHARED if `bus_shared_in` is 1 with the grant, and CLEAN-EXCLUSIVE otherwise.
- R3: A read hit in any valid state finishes with `cpu_done` and issues no bus transaction.
- R4: A write miss issues READ-OWN (code 1) at the request address, and the line becomes DIRTY-EXCLUSIVE.
- R5: A write hit on CLEAN-SHARED or DIRTY-OWNED issues INVALIDATE (code 2) at the request address before the line becomes DIRTY-EXCLUSIVE. A write hit on CLEAN-EXCLUSIVE or DIRTY-EXCLUSIVE becomes DIRTY-EXCLUSIVE with no bus transaction.
- R6: A miss whose victim line is DIRTY-EXCLUSIVE or DIRTY-OWNED first issues WRITEBACK (code 3) at the victim address {victim tag, index}, and only then the fill command.
- R7: A snooped READ that hits a dirty line pulses `snp_intervene` and `snp_reflect` together one cycle later. DIRTY-EXCLUSIVE becomes DIRTY-OWNED; DIRTY-OWNED stays DIRTY-OWNED.
- R8: A snooped READ that hits any valid line pulses `snp_shared_out` one cycle later. CLEAN-EXCLUSIVE becomes CLEAN-SHARED, and a clean line gives no intervention.
- R9: A snooped READ-OWN or INVALIDATE that hits a valid line makes it INVALID. If the line was dirty, intervention and reflect pulse first; the shared response stays 0.
- R10: A snooped WRITEBACK, or any snoop that misses, produces no response and leaves every line unchanged.
- R11: A snoop to a different index is answered one cycle after it arrives, even while a local request is waiting for the bus, and the pending request is not disturbed.
- R12: While `bus_req` is 1 and no grant has arrived, `bus_cmd` and `bus_addr` hold steady. `bus_req` is 0 whenever `cpu_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle local request, accepted while `cpu_ready` |
| cpu_we | input | 1 | 1 for a write request |
| cpu_addr | input | ADDR_W | Line address of the local request |
| cpu_ready | output | 1 | Request engine idle |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 2 | 0 READ, 1 READ-OWN, 2 INVALIDATE, 3 WRITEBACK |
| bus_addr | output | ADDR_W | Line address of the pending transaction |
| bus_gnt | input | 1 | One-cycle grant that completes the pending transaction |
| bus_shared_in | input | 1 | Another cache holds the line, sampled with the grant |
| snp_valid | input | 1 | A transaction from another master is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction, same codes as `bus_cmd` |
| snp_addr | input | ADDR_W | Line address of the snooped transaction |
| snp_shared_out | output | 1 | This cache holds the snooped line |
| snp_intervene | output | 1 | This cache supplies the dirty line itself |
| snp_reflect | output | 1 | Memory is to capture the intervened data |

## Verification
Directed cases walk each state through every local access and every snoop command: write upgrades from shared and from owned, a double snoop read on an owned line, a kill on a clean line, and an ignored write-back. Each of these separates two transitions that differ only in whether intervention or an invalidate is expected. Random traffic over four tags that alias onto sixteen indices forces frequent dirty and clean evictions. A random shared response at every grant splits exclusive fills from shared ones. Snoops aimed at other indices while a request waits for its grant show whether the two tag copies really run independently and whether the bus request stays intact.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        LS_INVALID   = 3'd0,
        LS_CLEAN_EX  = 3'd1,
        LS_CLEAN_SH  = 3'd2,
        LS_DIRTY_EX  = 3'd3,
        LS_DIRTY_OWN = 3'd4
    } line_state_t;

    typedef enum logic [1:0] {
        BC_READ     = 2'd0,
        BC_READ_OWN = 2'd1,
        BC_KILL     = 2'd2,
        BC_WRBACK   = 2'd3
    } bus_cmd_t;

    function automatic logic is_dirty(line_state_t s);
        return (s == LS_DIRTY_EX) || (s == LS_DIRTY_OWN);
    endfunction

    function automatic logic is_shared(line_state_t s);
        return (s == LS_CLEAN_SH) || (s == LS_DIRTY_OWN);
    endfunction

    // State reached by a valid line after another master's transaction.
    function automatic line_state_t snoop_next(line_state_t s, bus_cmd_t c);
        line_state_t n;
        n = s;
        unique case (c)
            BC_READ: begin
                if (s == LS_DIRTY_EX) n = LS_DIRTY_OWN;
                else if (s == LS_CLEAN_EX) n = LS_CLEAN_SH;
            end
            BC_READ_OWN, BC_KILL: n = LS_INVALID;
            BC_WRBACK: n = s;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/coh_tag_bank.sv
module coh_tag_bank
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    // state-only update from the snoop engine
    input  logic             sw_en,
    input  logic [IDX_W-1:0] sw_idx,
    input  line_state_t      sw_state,
    // tag and state update from the request engine
    input  logic             lw_en,
    input  logic [IDX_W-1:0] lw_idx,
    input  logic [TAG_W-1:0] lw_tag,
    input  line_state_t      lw_state,
    // private read port of this copy
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output line_state_t      rd_state
);

    logic [TAG_W-1:0] tag_q [NUM_LINES];
    line_state_t      st_q  [NUM_LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= LS_INVALID;
            end
        end else begin
            if (lw_en) begin
                tag_q[lw_idx] <= lw_tag;
                st_q[lw_idx]  <= lw_state;
            end
            // a snoop update is applied last, so it wins on a shared index
            if (sw_en) begin
                st_q[sw_idx] <= sw_state;
            end
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_state = st_q[rd_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 16,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    // snoop copy of the tag store
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  line_state_t       rd_state,
    output logic              sw_en,
    output logic [IDX_W-1:0]  sw_idx,
    output line_state_t       sw_state,
    // registered responses
    output logic              resp_shared,
    output logic              resp_intervene,
    output logic              resp_reflect
);

    bus_cmd_t   cmd;
    logic       hit;
    logic       shared_d;
    logic       intervene_d;
    logic       shared_q;
    logic       intervene_q;
    logic       reflect_q;

    assign cmd    = bus_cmd_t'(snp_cmd);
    assign rd_idx = snp_addr[IDX_W-1:0];
    assign sw_idx = snp_addr[IDX_W-1:0];

    always_comb begin
        hit         = snp_valid && (rd_state != LS_INVALID)
                      && (rd_tag == snp_addr[ADDR_W-1:IDX_W]);
        shared_d    = 1'b0;
        intervene_d = 1'b0;
        sw_en       = 1'b0;
        sw_state    = rd_state;
        if (hit) begin
            unique case (cmd)
                BC_READ: begin
                    shared_d    = 1'b1;
                    intervene_d = is_dirty(rd_state);
                end
                BC_READ_OWN, BC_KILL: begin
                    intervene_d = is_dirty(rd_state);
                end
                BC_WRBACK: begin
                    intervene_d = 1'b0;
                end
            endcase
            sw_state = snoop_next(rd_state, cmd);
            sw_en    = (sw_state != rd_state);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shared_q    <= 1'b0;
            intervene_q <= 1'b0;
            reflect_q   <= 1'b0;
        end else begin
            shared_q    <= shared_d;
            intervene_q <= intervene_d;
            reflect_q   <= intervene_d;
        end
    end

    assign resp_shared    = shared_q;
    assign resp_intervene = intervene_q;
    assign resp_reflect   = reflect_q;

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 16,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    // processor copy of the tag store
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  line_state_t       rd_state,
    output logic              lw_en,
    output logic [IDX_W-1:0]  lw_idx,
    output logic [TAG_W-1:0]  lw_tag,
    output line_state_t       lw_state,
    // concurrent snoop, index only
    input  logic              snp_valid,
    input  logic [IDX_W-1:0]  snp_idx,
    // bus master side
    output logic              bus_req,
    output bus_cmd_t          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in
);

    typedef enum logic [2:0] {
        F_IDLE, F_LOOKUP, F_WRBACK, F_FETCH, F_UPGRADE, F_DONE
    } fsm_state_t;

    fsm_state_t       state_q, state_d;
    logic             we_q;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    logic             hit;
    logic             clash;

    assign rd_idx = idx_q;
    assign lw_idx = idx_q;
    assign hit    = (rd_state != LS_INVALID) && (rd_tag == tag_q);
    assign clash  = snp_valid && (snp_idx == idx_q);

    // state register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= F_IDLE;
            we_q    <= 1'b0;
            idx_q   <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == F_IDLE && cpu_req) begin
                we_q  <= cpu_we;
                idx_q <= cpu_addr[IDX_W-1:0];
                tag_q <= cpu_addr[ADDR_W-1:IDX_W];
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE: if (cpu_req) state_d = F_LOOKUP;
            F_LOOKUP: begin
                if (clash) begin
                    state_d = F_LOOKUP;
                end else if (hit) begin
                    if (we_q && is_shared(rd_state)) state_d = F_UPGRADE;
                    else                              state_d = F_DONE;
                end else if (is_dirty(rd_state)) begin
                    state_d = F_WRBACK;
                end else begin
                    state_d = F_FETCH;
                end
            end
            F_WRBACK:  if (bus_gnt) state_d = F_FETCH;
                       else if (clash) state_d = F_LOOKUP;
            F_FETCH:   if (bus_gnt) state_d = F_DONE;
                       else if (clash) state_d = F_LOOKUP;
            F_UPGRADE: if (bus_gnt) state_d = F_DONE;
                       else if (clash) state_d = F_LOOKUP;
            F_DONE:    state_d = F_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_ready = 1'b0;
        cpu_done  = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = BC_READ;
        bus_addr  = {tag_q, idx_q};
        lw_en     = 1'b0;
        lw_tag    = tag_q;
        lw_state  = LS_INVALID;
        unique case (state_q)
            F_IDLE: cpu_ready = 1'b1;
            F_LOOKUP: begin
                if (!clash && hit && we_q && !is_shared(rd_state)) begin
                    lw_en    = 1'b1;
                    lw_state = LS_DIRTY_EX;
                end
            end
            F_WRBACK: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_WRBACK;
                bus_addr = {rd_tag, idx_q};
                if (bus_gnt) begin
                    lw_en    = 1'b1;
                    lw_tag   = rd_tag;
                    lw_state = LS_INVALID;
                end
            end
            F_FETCH: begin
                bus_req = 1'b1;
                bus_cmd = we_q ? BC_READ_OWN : BC_READ;
                if (bus_gnt) begin
                    lw_en = 1'b1;
                    if (we_q)               lw_state = LS_DIRTY_EX;
                    else if (bus_shared_in) lw_state = LS_CLEAN_SH;
                    else                    lw_state = LS_CLEAN_EX;
                end
            end
            F_UPGRADE: begin
                bus_req = 1'b1;
                bus_cmd = BC_KILL;
                if (bus_gnt) begin
                    lw_en    = 1'b1;
                    lw_state = LS_DIRTY_EX;
                end
            end
            F_DONE: cpu_done = 1'b1;
        endcase
    end

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared_out,
    output logic              snp_intervene,
    output logic              snp_reflect
);

    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int TAG_W   = ADDR_W - IDX_W;
    localparam int NCOPIES = 2;   // copy 0: processor side, copy 1: snoop side

    logic [IDX_W-1:0] bank_rd_idx   [NCOPIES];
    logic [TAG_W-1:0] bank_rd_tag   [NCOPIES];
    line_state_t      bank_rd_state [NCOPIES];

    logic             sw_en;
    logic [IDX_W-1:0] sw_idx;
    line_state_t      sw_state;
    logic             lw_en;
    logic [IDX_W-1:0] lw_idx;
    logic [TAG_W-1:0] lw_tag;
    line_state_t      lw_state;
    bus_cmd_t         req_cmd;

    for (genvar g = 0; g < NCOPIES; g++) begin : g_copy
        coh_tag_bank #(
            .NUM_LINES(NUM_LINES),
            .TAG_W    (TAG_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_en   (sw_en),
            .sw_idx  (sw_idx),
            .sw_state(sw_state),
            .lw_en   (lw_en),
            .lw_idx  (lw_idx),
            .lw_tag  (lw_tag),
            .lw_state(lw_state),
            .rd_idx  (bank_rd_idx[g]),
            .rd_tag  (bank_rd_tag[g]),
            .rd_state(bank_rd_state[g])
        );
    end

    coh_req_fsm #(
        .ADDR_W   (ADDR_W),
        .NUM_LINES(NUM_LINES)
    ) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_ready    (cpu_ready),
        .cpu_done     (cpu_done),
        .rd_idx       (bank_rd_idx[0]),
        .rd_tag       (bank_rd_tag[0]),
        .rd_state     (bank_rd_state[0]),
        .lw_en        (lw_en),
        .lw_idx       (lw_idx),
        .lw_tag       (lw_tag),
        .lw_state     (lw_state),
        .snp_valid    (snp_valid),
        .snp_idx      (snp_addr[IDX_W-1:0]),
        .bus_req      (bus_req),
        .bus_cmd      (req_cmd),
        .bus_addr     (bus_addr),
        .bus_gnt      (bus_gnt),
        .bus_shared_in(bus_shared_in)
    );

    assign bus_cmd = req_cmd;

    coh_snoop_unit #(
        .ADDR_W   (ADDR_W),
        .NUM_LINES(NUM_LINES)
    ) u_snoop (
        .clk           (clk),
        .rst_n         (rst_n),
        .snp_valid     (snp_valid),
        .snp_cmd       (snp_cmd),
        .snp_addr      (snp_addr),
        .rd_idx        (bank_rd_idx[1]),
        .rd_tag        (bank_rd_tag[1]),
        .rd_state      (bank_rd_state[1]),
        .sw_en         (sw_en),
        .sw_idx        (sw_idx),
        .sw_state      (sw_state),
        .resp_shared   (snp_shared_out),
        .resp_intervene(snp_intervene),
        .resp_reflect  (snp_reflect)
    );

endmodule

// File: rtl/coh_snoop_ctrl_chk.sv
module coh_snoop_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              bus_req,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_gnt,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic              snp_shared_out,
    input logic              snp_intervene,
    input logic              snp_reflect
);

    // R12: an idle engine never requests the bus
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !bus_req);

    // R12: an ungranted request is held unchanged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=>
            (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R8: a shared response only follows a snooped read
    p_shared_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared_out |-> ($past(snp_valid) && $past(snp_cmd) == 2'd0));

    // R9: intervention never answers a snooped write-back
    p_intervene_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_intervene |-> ($past(snp_valid) && $past(snp_cmd) != 2'd3));

    // R10: no snoop response without a snoop in the cycle before
    p_silent_without_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(snp_valid) |-> !(snp_shared_out || snp_intervene || snp_reflect));

    // R3: completion is a single pulse followed by the idle state
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> (cpu_ready && !cpu_done));

endmodule

bind coh_snoop_ctrl coh_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_ready     (cpu_ready),
    .cpu_done      (cpu_done),
    .bus_req       (bus_req),
    .bus_cmd       (bus_cmd),
    .bus_addr      (bus_addr),
    .bus_gnt       (bus_gnt),
    .snp_valid     (snp_valid),
    .snp_cmd       (snp_cmd),
    .snp_shared_out(snp_shared_out),
    .snp_intervene (snp_intervene),
    .snp_reflect   (snp_reflect)
);

// File: tb/tb_coh_snoop_ctrl.sv
module tb_coh_snoop_ctrl;

    localparam int ADDR_W = 12;
    localparam int LINES  = 16;
    // bus command codes
    localparam int C_RD = 0, C_RDOWN = 1, C_KILL = 2, C_WB = 3;
    // model state codes
    localparam int S_INV = 0, S_CEX = 1, S_CSH = 2, S_DEX = 3, S_DOWN = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_ready;
    logic              cpu_done;
    logic              bus_req;
    logic [1:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_gnt = 1'b0;
    logic              bus_shared_in = 1'b0;
    logic              snp_valid = 1'b0;
    logic [1:0]        snp_cmd = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_shared_out;
    logic              snp_intervene;
    logic              snp_reflect;

    coh_snoop_ctrl #(.ADDR_W(ADDR_W), .NUM_LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared_out(snp_shared_out), .snp_intervene(snp_intervene),
        .snp_reflect(snp_reflect)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int m_tag [LINES];
    int m_st  [LINES];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit dirty(input int s);
        return (s == S_DEX) || (s == S_DOWN);
    endfunction

    function automatic bit sharedst(input int s);
        return (s == S_CSH) || (s == S_DOWN);
    endfunction

    // Snoop a transaction from another master; called at a falling edge.
    task automatic do_snoop(input int cmd, input int addr, input string req);
        int  idx = addr % LINES;
        int  tg  = addr / LINES;
        bit  hit = (m_st[idx] != S_INV) && (m_tag[idx] == tg);
        bit  e_sh  = hit && (cmd == C_RD);
        bit  e_int = hit && dirty(m_st[idx]) && (cmd != C_WB);
        if (hit) begin
            if (cmd == C_RD) begin
                if (m_st[idx] == S_DEX) m_st[idx] = S_DOWN;
                else if (m_st[idx] == S_CEX) m_st[idx] = S_CSH;
            end else if (cmd != C_WB) begin
                m_st[idx] = S_INV;
            end
        end
        snp_valid = 1'b1;
        snp_cmd   = cmd[1:0];
        snp_addr  = addr[ADDR_W-1:0];
        @(negedge clk);
        snp_valid = 1'b0;
        check(snp_shared_out == e_sh, {req, " shared"}, snp_shared_out, e_sh);
        check(snp_intervene == e_int, {req, " intervene"}, snp_intervene, e_int);
        check(snp_reflect == e_int, {req, " reflect"}, snp_reflect, e_int);
    endtask

    // Local request. sh_mode: 0/1 forces the shared response, 2 picks it at random.
    task automatic do_cpu(input bit we, input int addr, input int sh_mode,
                          input bit allow_snoop, input string req);
        int idx = addr % LINES;
        int tg  = addr / LINES;
        int st  = m_st[idx];
        bit hit = (st != S_INV) && (m_tag[idx] == tg);
        int exp_cmd [2];
        int exp_adr [2];
        int n_exp = 0;
        int k = 0;
        int wd = 0;
        bit done_seen = 1'b0;
        bit last_sh = 1'b0;
        if (hit) begin
            if (we && sharedst(st)) begin
                exp_cmd[0] = C_KILL; exp_adr[0] = addr; n_exp = 1;
            end
        end else begin
            if (dirty(st)) begin
                exp_cmd[n_exp] = C_WB; exp_adr[n_exp] = m_tag[idx] * LINES + idx; n_exp++;
            end
            exp_cmd[n_exp] = we ? C_RDOWN : C_RD; exp_adr[n_exp] = addr; n_exp++;
        end
        while (!cpu_ready) @(negedge clk);
        cpu_req  = 1'b1;
        cpu_we   = we;
        cpu_addr = addr[ADDR_W-1:0];
        @(negedge clk);
        cpu_req = 1'b0;
        while (!done_seen && wd < 1000) begin
            if (cpu_done) begin
                done_seen = 1'b1;
            end else if (bus_req) begin
                if (k < n_exp) begin
                    check(int'(bus_cmd) == exp_cmd[k], {req, " bus command"}, bus_cmd, exp_cmd[k]);
                    check(int'(bus_addr) == exp_adr[k], {req, " bus address"}, bus_addr, exp_adr[k]);
                end else begin
                    check(1'b0, {req, " unexpected bus transaction"}, k, n_exp);
                end
                if (allow_snoop && ($urandom % 2 == 1)) begin
                    int idx2 = (idx + 1 + int'($urandom % (LINES - 1))) % LINES;
                    int tg2  = int'($urandom % 4);
                    do_snoop(int'($urandom % 4), tg2 * LINES + idx2, "R11 concurrent snoop");
                    check(bus_req == 1'b1, "R11 request kept across snoop", bus_req, 1);
                end
                begin
                    int held_cmd = int'(bus_cmd);
                    int held_adr = int'(bus_addr);
                    repeat (int'($urandom % 3)) @(negedge clk);
                    check(bus_req && int'(bus_cmd) == held_cmd && int'(bus_addr) == held_adr,
                          "R12 request held until grant", bus_cmd, held_cmd);
                end
                last_sh = (sh_mode == 2) ? 1'($urandom % 2) : sh_mode[0];
                bus_gnt       = 1'b1;
                bus_shared_in = last_sh;
                @(negedge clk);
                bus_gnt       = 1'b0;
                bus_shared_in = 1'b0;
                k++;
            end else begin
                @(negedge clk);
                wd++;
            end
        end
        check(done_seen, {req, " completion"}, done_seen, 1);
        check(k == n_exp, {req, " transaction count"}, k, n_exp);
        if (hit) begin
            if (we) m_st[idx] = S_DEX;
        end else begin
            m_tag[idx] = tg;
            m_st[idx]  = we ? S_DEX : (last_sh ? S_CSH : S_CEX);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < LINES; i++) begin
            m_tag[i] = 0;
            m_st[i]  = S_INV;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cpu_ready == 1'b1, "R1 ready after reset", cpu_ready, 1);
        check(bus_req == 1'b0, "R1 no request after reset", bus_req, 0);
        check(!(snp_shared_out || snp_intervene || snp_reflect), "R1 responses idle", snp_shared_out, 0);
        do_snoop(C_RD, 16 * 2 + 5, "R1 snoop on empty cache");

        // R2 clean-exclusive fill, then R8 downgrade to shared
        do_cpu(1'b0, 16 * 1 + 3, 0, 1'b0, "R2 read miss exclusive");
        do_snoop(C_RD, 16 * 1 + 3, "R8 snoop read on exclusive clean");
        // R5 upgrade from shared
        do_cpu(1'b1, 16 * 1 + 3, 0, 1'b0, "R5 write to shared clean");
        // R3 read hit on dirty line
        do_cpu(1'b0, 16 * 1 + 3, 0, 1'b0, "R3 read hit");
        // R7 intervention twice: dirty exclusive then owned
        do_snoop(C_RD, 16 * 1 + 3, "R7 snoop read on dirty exclusive");
        do_snoop(C_RD, 16 * 1 + 3, "R7 snoop read on owned");
        // R5 upgrade from owned
        do_cpu(1'b1, 16 * 1 + 3, 0, 1'b0, "R5 write to owned");
        // R6 dirty victim write-back, shared fill
        do_cpu(1'b0, 16 * 2 + 3, 1, 1'b0, "R6 eviction of dirty line");
        // R10 write-back snoop ignored, then R9 kill on clean line
        do_snoop(C_WB, 16 * 2 + 3, "R10 snooped write-back");
        do_snoop(C_KILL, 16 * 2 + 3, "R9 invalidate on clean shared");
        do_cpu(1'b0, 16 * 2 + 3, 0, 1'b0, "R9 line invalid after kill");
        // R4 write miss, then R9 read-own steals dirty line
        do_cpu(1'b1, 16 * 3 + 9, 0, 1'b0, "R4 write miss");
        do_snoop(C_RDOWN, 16 * 3 + 9, "R9 read-own on dirty line");
        do_cpu(1'b0, 16 * 3 + 9, 0, 1'b0, "R9 refetch after steal");
        // R5 silent upgrade from clean exclusive
        do_cpu(1'b0, 16 * 0 + 7, 0, 1'b0, "R2 read miss for silent upgrade");
        do_cpu(1'b1, 16 * 0 + 7, 0, 1'b0, "R5 write to exclusive clean");
        do_snoop(C_RD, 16 * 0 + 7, "R7 dirty after silent upgrade");
        // R10 snoop miss on a different tag
        do_snoop(C_KILL, 16 * 1 + 7, "R10 snoop miss");
        do_cpu(1'b0, 16 * 0 + 7, 0, 1'b0, "R10 line kept after snoop miss");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int a = int'($urandom % 4) * LINES + int'($urandom % LINES);
            if ($urandom % 3 == 0) begin
                do_snoop(int'($urandom % 4), a, "R7 R8 R9 R10 random snoop");
            end else begin
                do_cpu(1'($urandom % 2), a, 2, 1'b1, "R2 R3 R4 R5 R6 random request");
            end
        end

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule